// File: doc/BRIEF.md
# Branch and Skip Flow Resolver

This block works out where the program counter goes next after a conditional branch or a skip instruction in a small 8-bit processor, and how many cycles the sequencer has to spend on that instruction. Each cycle it takes several inputs: the status byte, a flow kind, a bit index, a signed 7-bit displacement, the current PC, the register operand and the I/O operand used for bit tests, an equality result from the comparator, and a flag that says whether the instruction after this one is two words long. From these it registers the next PC, a cycle count and a taken indication.

Fetch, decode and the register comparison itself happen outside the block. The sequencer drives the inputs for one instruction and, one clock later, loads the PC from `next_pc_o` and stalls for `cycles_o` minus one cycles.

Top module: `bsc_flow_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs become next_pc 0, cycles 1 and taken 0.
- R2: Kind 0 is taken when `status_i[bit_sel_i]` is 1. Kind 1 is taken when that bit is 0. The status bit positions are C=0, Z=1, N=2, V=3, S=4, H=5, T=6 and I=7, so the interrupt-enable, T, half-carry and overflow branches are kinds 0 and 1 with bit index 7, 6, 5 or 3.
- R3: A taken branch (kinds 0 to 5) gives PC + sext(offset) + 1 and 2 cycles. A branch that is not taken gives PC + 1 and 1 cycle.
- R4: Kind 2 (signed greater-or-equal) is taken when N XOR V is 0. Kind 3 (signed less-than) is taken when N XOR V is 1.
- R5: Kind 4 (unsigned same-or-higher) is taken when C is 0. Kind 5 (unsigned lower) is taken when C is 1.
- R6: The 7-bit offset is sign-extended, and all PC arithmetic wraps modulo 2^PC_W.
- R7: A skip that happens gives PC + 2 and 2 cycles when `two_word_i` is 0. It gives PC + 3 and 3 cycles when `two_word_i` is 1. A skip that does not happen gives PC + 1 and 1 cycle, and `two_word_i` has no effect on it.
- R8: Kind 6 skips when `equal_i` is 1.
- R9: Kind 7 skips when `reg_val_i[bit_sel_i]` is 0, and kind 8 skips when that bit is 1. `io_val_i` does not affect these kinds.
- R10: Kind 9 skips when `io_val_i[bit_sel_i]` is 0, and kind 10 skips when that bit is 1. `reg_val_i` does not affect these kinds.
- R11: Kinds 11 to 15 give PC + 1, 1 cycle and taken 0, whatever the flags and operands are.
- R12: The outputs reflect the inputs sampled at the previous rising edge, one register stage deep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kind_i | input | 4 | Flow kind code |
| status_i | input | 8 | Processor status byte |
| bit_sel_i | input | 3 | Bit index for status, register or I/O tests |
| offset_i | input | 7 | Signed branch displacement |
| pc_i | input | PC_W | Current program counter |
| reg_val_i | input | 8 | Register operand for bit-test skips |
| io_val_i | input | 8 | I/O operand for bit-test skips |
| equal_i | input | 1 | Equality result from the comparator |
| two_word_i | input | 1 | The following instruction is two words long |
| next_pc_o | output | PC_W | Resolved next program counter |
| cycles_o | output | 2 | Cycles spent on the instruction (1 to 3) |
| taken_o | output | 1 | Branch taken or skip performed |

## Verification
The hardest cases to reach from the ports are the wrap-around cases: a taken branch near the top of the PC range that wraps past zero, and a negative displacement from PC 0 that wraps to the top. The stimulus loads PC values of 0xFFFF and 0x0000 directly, together with the extreme offsets +1 and -64. A second hard case is an operand that must have no effect. For this the bench puts a bit value into the unused operand that would flip the result if that operand were wrongly selected, and then checks the PC and the cycle count.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

    typedef enum logic [3:0] {
        K_BR_SET  = 4'd0,
        K_BR_CLR  = 4'd1,
        K_BR_GE   = 4'd2,
        K_BR_LT   = 4'd3,
        K_BR_SH   = 4'd4,
        K_BR_LO   = 4'd5,
        K_SK_EQ   = 4'd6,
        K_SK_RBC  = 4'd7,
        K_SK_RBS  = 4'd8,
        K_SK_IOC  = 4'd9,
        K_SK_IOS  = 4'd10,
        K_STEP    = 4'd11
    } flow_kind_e;

    typedef enum logic [1:0] {
        CL_SEQ    = 2'd0,
        CL_BRANCH = 2'd1,
        CL_SKIP   = 2'd2
    } flow_class_e;

    localparam int FLAG_C = 0;
    localparam int FLAG_Z = 1;
    localparam int FLAG_N = 2;
    localparam int FLAG_V = 3;
    localparam int FLAG_S = 4;
    localparam int FLAG_H = 5;
    localparam int FLAG_T = 6;
    localparam int FLAG_I = 7;

    localparam int CYC_W = 2;

    typedef struct packed {
        logic        hit;
        flow_class_e cls;
    } cond_res_t;

    typedef struct packed {
        logic [CYC_W-1:0] cycles;
        logic             taken;
    } cost_t;

    function automatic flow_class_e class_of(input logic [3:0] k);
        if (k <= 4'd5)       return CL_BRANCH;
        else if (k <= 4'd10) return CL_SKIP;
        else                 return CL_SEQ;
    endfunction

endpackage

// File: rtl/bsc_cond_eval.sv
module bsc_cond_eval
    import bsc_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int SEL_W = $clog2(DATA_W)
) (
    input  logic [3:0]        kind_i,
    input  logic [DATA_W-1:0] status_i,
    input  logic [SEL_W-1:0]  bit_sel_i,
    input  logic [DATA_W-1:0] reg_val_i,
    input  logic [DATA_W-1:0] io_val_i,
    input  logic              equal_i,
    output cond_res_t         res_o
);
    logic sel_status, sel_reg, sel_io, signed_lt;

    assign sel_status = status_i[bit_sel_i];
    assign sel_reg    = reg_val_i[bit_sel_i];
    assign sel_io     = io_val_i[bit_sel_i];
    assign signed_lt  = status_i[FLAG_N] ^ status_i[FLAG_V];

    always_comb begin
        res_o.cls = class_of(kind_i);
        unique case (kind_i)
            K_BR_SET: res_o.hit = sel_status;
            K_BR_CLR: res_o.hit = !sel_status;
            K_BR_GE:  res_o.hit = !signed_lt;
            K_BR_LT:  res_o.hit = signed_lt;
            K_BR_SH:  res_o.hit = !status_i[FLAG_C];
            K_BR_LO:  res_o.hit = status_i[FLAG_C];
            K_SK_EQ:  res_o.hit = equal_i;
            K_SK_RBC: res_o.hit = !sel_reg;
            K_SK_RBS: res_o.hit = sel_reg;
            K_SK_IOC: res_o.hit = !sel_io;
            K_SK_IOS: res_o.hit = sel_io;
            default:  res_o.hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/bsc_target_calc.sv
module bsc_target_calc
    import bsc_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int OFF_W = 7
) (
    input  logic [PC_W-1:0]  pc_i,
    input  logic [OFF_W-1:0] offset_i,
    input  logic             two_word_i,
    input  cond_res_t        res_i,
    output logic [PC_W-1:0]  next_pc_o,
    output cost_t            cost_o
);
    localparam int EXT_W = PC_W - OFF_W;

    logic [PC_W-1:0] disp_ext, pc_step, pc_branch, pc_skip;

    assign disp_ext  = {{EXT_W{offset_i[OFF_W-1]}}, offset_i};
    assign pc_step   = pc_i + PC_W'(1);
    assign pc_branch = pc_step + disp_ext;
    assign pc_skip   = pc_i + (two_word_i ? PC_W'(3) : PC_W'(2));

    always_comb begin
        next_pc_o    = pc_step;
        cost_o.cycles = CYC_W'(1);
        cost_o.taken  = 1'b0;
        if (res_i.hit) begin
            unique case (res_i.cls)
                CL_BRANCH: begin
                    next_pc_o     = pc_branch;
                    cost_o.cycles = CYC_W'(2);
                    cost_o.taken  = 1'b1;
                end
                CL_SKIP: begin
                    next_pc_o     = pc_skip;
                    cost_o.cycles = two_word_i ? CYC_W'(3) : CYC_W'(2);
                    cost_o.taken  = 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/bsc_flow_unit.sv
module bsc_flow_unit
    import bsc_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int OFF_W  = 7,
    parameter int DATA_W = 8,
    localparam int SEL_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        kind_i,
    input  logic [DATA_W-1:0] status_i,
    input  logic [SEL_W-1:0]  bit_sel_i,
    input  logic [OFF_W-1:0]  offset_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [DATA_W-1:0] reg_val_i,
    input  logic [DATA_W-1:0] io_val_i,
    input  logic              equal_i,
    input  logic              two_word_i,
    output logic [PC_W-1:0]   next_pc_o,
    output logic [CYC_W-1:0]  cycles_o,
    output logic              taken_o
);
    cond_res_t       cond;
    cost_t           cost;
    logic [PC_W-1:0] pc_nxt;

    bsc_cond_eval #(.DATA_W(DATA_W)) u_cond (
        .kind_i    (kind_i),
        .status_i  (status_i),
        .bit_sel_i (bit_sel_i),
        .reg_val_i (reg_val_i),
        .io_val_i  (io_val_i),
        .equal_i   (equal_i),
        .res_o     (cond)
    );

    bsc_target_calc #(.PC_W(PC_W), .OFF_W(OFF_W)) u_target (
        .pc_i       (pc_i),
        .offset_i   (offset_i),
        .two_word_i (two_word_i),
        .res_i      (cond),
        .next_pc_o  (pc_nxt),
        .cost_o     (cost)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            next_pc_o <= '0;
            cycles_o  <= CYC_W'(1);
            taken_o   <= 1'b0;
        end else begin
            next_pc_o <= pc_nxt;
            cycles_o  <= cost.cycles;
            taken_o   <= cost.taken;
        end
    end
endmodule

// File: rtl/bsc_flow_unit_chk.sv
module bsc_flow_unit_chk #(
    parameter int PC_W  = 16,
    parameter int OFF_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic [3:0]       kind_i,
    input logic [OFF_W-1:0] offset_i,
    input logic [PC_W-1:0]  pc_i,
    input logic             two_word_i,
    input logic [PC_W-1:0]  next_pc_o,
    input logic [1:0]       cycles_o,
    input logic             taken_o
);
    logic primed;
    always_ff @(posedge clk) primed <= !rst;

    logic [PC_W-1:0] chk_inc, chk_br, chk_sk;
    assign chk_inc = pc_i + PC_W'(1);
    assign chk_br  = pc_i + PC_W'($signed(offset_i)) + PC_W'(1);
    assign chk_sk  = pc_i + PC_W'(2) + PC_W'(two_word_i);

    p_cycle_bound_r7: assert property (@(posedge clk) disable iff (rst)
        cycles_o != 2'd0);

    p_not_taken_step_r3: assert property (@(posedge clk) disable iff (rst)
        primed && !taken_o |-> next_pc_o == $past(chk_inc) && cycles_o == 2'd1);

    p_branch_target_r3: assert property (@(posedge clk) disable iff (rst)
        primed && taken_o && $past(kind_i) <= 4'd5
        |-> next_pc_o == $past(chk_br) && cycles_o == 2'd2);

    p_skip_distance_r7: assert property (@(posedge clk) disable iff (rst)
        primed && taken_o && $past(kind_i) >= 4'd6 && $past(kind_i) <= 4'd10
        |-> next_pc_o == $past(chk_sk) && cycles_o == 2'd2 + 2'($past(two_word_i)));

    p_step_never_taken_r11: assert property (@(posedge clk) disable iff (rst)
        primed && $past(kind_i) >= 4'd11 |-> !taken_o);

    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) |-> next_pc_o == '0 && cycles_o == 2'd1 && !taken_o);
endmodule

bind bsc_flow_unit bsc_flow_unit_chk #(.PC_W(PC_W), .OFF_W(OFF_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .kind_i     (kind_i),
    .offset_i   (offset_i),
    .pc_i       (pc_i),
    .two_word_i (two_word_i),
    .next_pc_o  (next_pc_o),
    .cycles_o   (cycles_o),
    .taken_o    (taken_o)
);

// File: tb/bsc_flow_unit_tb.sv
module bsc_flow_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  kind_i;
    logic [7:0]  status_i;
    logic [2:0]  bit_sel_i;
    logic [6:0]  offset_i;
    logic [15:0] pc_i;
    logic [7:0]  reg_val_i;
    logic [7:0]  io_val_i;
    logic        equal_i;
    logic        two_word_i;
    logic [15:0] next_pc_o;
    logic [1:0]  cycles_o;
    logic        taken_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bsc_flow_unit u_dut (
        .clk(clk), .rst(rst), .kind_i(kind_i), .status_i(status_i),
        .bit_sel_i(bit_sel_i), .offset_i(offset_i), .pc_i(pc_i),
        .reg_val_i(reg_val_i), .io_val_i(io_val_i), .equal_i(equal_i),
        .two_word_i(two_word_i), .next_pc_o(next_pc_o),
        .cycles_o(cycles_o), .taken_o(taken_o)
    );

    task automatic expect_out(input string req, input logic [15:0] epc,
                              input logic [1:0] ecyc, input logic etk);
        checks++;
        if (next_pc_o !== epc || cycles_o !== ecyc || taken_o !== etk) begin
            errors++;
            $display("FAIL %s: got pc=%h cyc=%0d tk=%0b, expected pc=%h cyc=%0d tk=%0b",
                     req, next_pc_o, cycles_o, taken_o, epc, ecyc, etk);
        end
    endtask

    task automatic drive(input logic [3:0] k, input logic [7:0] st, input logic [2:0] bs,
                         input logic [6:0] off, input logic [15:0] pc,
                         input logic [7:0] rv, input logic [7:0] iv,
                         input logic eq, input logic tw);
        kind_i = k; status_i = st; bit_sel_i = bs; offset_i = off; pc_i = pc;
        reg_val_i = rv; io_val_i = iv; equal_i = eq; two_word_i = tw;
        @(posedge clk); #1;
    endtask

    task automatic t_reset_r1();
        rst = 1'b1;
        drive(4'd6, 8'h00, 3'd0, 7'd0, 16'h1234, 8'h00, 8'h00, 1'b1, 1'b1);
        expect_out("R1 reset", 16'h0000, 2'd1, 1'b0);
        rst = 1'b0;
    endtask

    task automatic t_generic_flag_r2();
        drive(4'd0, 8'h40, 3'd6, 7'd5, 16'd100, 8'h00, 8'h00, 1'b0, 1'b0);
        expect_out("R2 T set taken", 16'd106, 2'd2, 1'b1);
        drive(4'd0, 8'hBF, 3'd6, 7'd5, 16'd100, 8'h00, 8'h00, 1'b0, 1'b0);
        expect_out("R2 T clear not taken", 16'd101, 2'd1, 1'b0);
        drive(4'd1, 8'h7F, 3'd7, 7'h7D, 16'd100, 8'h00, 8'h00, 1'b0, 1'b0);
        expect_out("R2 I clear branch", 16'd98, 2'd2, 1'b1);
        drive(4'd0, 8'h20, 3'd5, 7'd10, 16'd50, 8'h00, 8'h00, 1'b0, 1'b0);
        expect_out("R2 H set branch", 16'd61, 2'd2, 1'b1);
    endtask

    task automatic t_branch_timing_r3();
        drive(4'd1, 8'h08, 3'd3, 7'd20, 16'd300, 8'h00, 8'h00, 1'b0, 1'b1);
        expect_out("R3 V set no branch", 16'd301, 2'd1, 1'b0);
        drive(4'd1, 8'h00, 3'd3, 7'd20, 16'd300, 8'h00, 8'h00, 1'b0, 1'b1);
        expect_out("R3 V clear branch", 16'd321, 2'd2, 1'b1);
    endtask

    task automatic t_signed_r4();
        drive(4'd2, 8'h0C, 3'd0, 7'd4, 16'd10, 8'h00, 8'h00, 1'b0, 1'b0);
        expect_out("R4 GE N=V=1", 16'd15, 2'd2, 1'b1);
        drive(4'd3, 8'h0C, 3'd0, 7'd4, 16'd10, 8'h00, 8'h00, 1'b0, 1'b0);
        expect_out("R4 LT N=V=1", 16'd11, 2'd1, 1'b0);
        drive(4'd3, 8'h04, 3'd0, 7'd4, 16'd10, 8'h00, 8'h00, 1'b0, 1'b0);
        expect_out("R4 LT N=1 V=0", 16'd15, 2'd2, 1'b1);
        drive(4'd2, 8'h08, 3'd0, 7'd4, 16'd10, 8'h00, 8'h00, 1'b0, 1'b0);
        expect_out("R4 GE N=0 V=1", 16'd11, 2'd1, 1'b0);
    endtask

    task automatic t_unsigned_r5();
        drive(4'd4, 8'hFE, 3'd0, 7'd2, 16'd40, 8'h00, 8'h00, 1'b0, 1'b0);
        expect_out("R5 SH C=0", 16'd43, 2'd2, 1'b1);
        drive(4'd5, 8'hFE, 3'd0, 7'd2, 16'd40, 8'h00, 8'h00, 1'b0, 1'b0);
        expect_out("R5 LO C=0", 16'd41, 2'd1, 1'b0);
        drive(4'd5, 8'h01, 3'd0, 7'd2, 16'd40, 8'h00, 8'h00, 1'b0, 1'b0);
        expect_out("R5 LO C=1", 16'd43, 2'd2, 1'b1);
    endtask

    task automatic t_wrap_r6();
        drive(4'd0, 8'h01, 3'd0, 7'd1, 16'hFFFF, 8'h00, 8'h00, 1'b0, 1'b0);
        expect_out("R6 wrap up", 16'h0001, 2'd2, 1'b1);
        drive(4'd0, 8'h01, 3'd0, 7'h40, 16'h0000, 8'h00, 8'h00, 1'b0, 1'b0);
        expect_out("R6 wrap down -64", 16'hFFC1, 2'd2, 1'b1);
        drive(4'd6, 8'h00, 3'd0, 7'd0, 16'hFFFE, 8'h00, 8'h00, 1'b1, 1'b1);
        expect_out("R6 skip wrap", 16'h0001, 2'd3, 1'b1);
    endtask

    task automatic t_skip_eq_r7_r8();
        drive(4'd6, 8'h00, 3'd0, 7'd9, 16'd200, 8'h00, 8'h00, 1'b1, 1'b0);
        expect_out("R8 eq skip one word R7", 16'd202, 2'd2, 1'b1);
        drive(4'd6, 8'h00, 3'd0, 7'd9, 16'd200, 8'h00, 8'h00, 1'b1, 1'b1);
        expect_out("R8 eq skip two words R7", 16'd203, 2'd3, 1'b1);
        drive(4'd6, 8'hFF, 3'd0, 7'd9, 16'd200, 8'h00, 8'h00, 1'b0, 1'b1);
        expect_out("R7 no skip two-word ignored", 16'd201, 2'd1, 1'b0);
    endtask

    task automatic t_reg_bit_r9();
        drive(4'd8, 8'h00, 3'd4, 7'd0, 16'd500, 8'h10, 8'h00, 1'b0, 1'b0);
        expect_out("R9 reg bit set skip", 16'd502, 2'd2, 1'b1);
        drive(4'd7, 8'h00, 3'd4, 7'd0, 16'd500, 8'h10, 8'h00, 1'b0, 1'b0);
        expect_out("R9 reg bit clr no skip io ignored", 16'd501, 2'd1, 1'b0);
        drive(4'd7, 8'h00, 3'd4, 7'd0, 16'd500, 8'hEF, 8'h10, 1'b0, 1'b1);
        expect_out("R9 reg bit clr skip", 16'd503, 2'd3, 1'b1);
    endtask

    task automatic t_io_bit_r10();
        drive(4'd10, 8'h00, 3'd1, 7'd0, 16'd700, 8'h02, 8'h00, 1'b0, 1'b0);
        expect_out("R10 io bit set no skip reg ignored", 16'd701, 2'd1, 1'b0);
        drive(4'd10, 8'h00, 3'd1, 7'd0, 16'd700, 8'h00, 8'h02, 1'b0, 1'b1);
        expect_out("R10 io bit set skip", 16'd703, 2'd3, 1'b1);
        drive(4'd9, 8'h00, 3'd1, 7'd0, 16'd700, 8'h00, 8'hFD, 1'b0, 1'b0);
        expect_out("R10 io bit clr skip", 16'd702, 2'd2, 1'b1);
    endtask

    task automatic t_step_r11();
        drive(4'd11, 8'hFF, 3'd0, 7'd30, 16'd900, 8'hFF, 8'hFF, 1'b1, 1'b1);
        expect_out("R11 step kind", 16'd901, 2'd1, 1'b0);
        drive(4'd15, 8'hFF, 3'd0, 7'd30, 16'd900, 8'h00, 8'h00, 1'b1, 1'b1);
        expect_out("R11 unused kind", 16'd901, 2'd1, 1'b0);
    endtask

    task automatic t_latency_r12();
        drive(4'd0, 8'h01, 3'd0, 7'd3, 16'd20, 8'h00, 8'h00, 1'b0, 1'b0);
        kind_i = 4'd11; pc_i = 16'd80;
        #2;
        expect_out("R12 holds until edge", 16'd24, 2'd2, 1'b1);
        @(posedge clk); #1;
        expect_out("R12 updates after edge", 16'd81, 2'd1, 1'b0);
        rst = 1'b1;
        @(posedge clk); #1;
        expect_out("R1 reset mid-run", 16'h0000, 2'd1, 1'b0);
        rst = 1'b0;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        kind_i = 4'd11; status_i = '0; bit_sel_i = '0; offset_i = '0; pc_i = '0;
        reg_val_i = '0; io_val_i = '0; equal_i = 1'b0; two_word_i = 1'b0;
        @(posedge clk); #1;
        t_reset_r1();
        t_generic_flag_r2();
        t_branch_timing_r3();
        t_signed_r4();
        t_unsigned_r5();
        t_wrap_r6();
        t_skip_eq_r7_r8();
        t_reg_bit_r9();
        t_io_bit_r10();
        t_step_r11();
        t_latency_r12();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule